// File: doc/BRIEF.md
# Two-Wire Debug Port Slave

This block is the target end of a two-wire debug link. The link has a debug clock that is only an input and a single data line that is shared in both directions, one direction at a time. The block watches the chip reset input. If the debug clock shows exactly two rising edges while reset is held low, the block switches into debug mode when reset is released. Until then, both pins stay ordinary general-purpose I/O and the block never drives them. A reset pulse with no clock edges at all returns the pins to general-purpose use.

In debug mode the host sends a command frame of one to four bytes. The command byte itself says how many operand bytes follow, and whether the host expects a byte back. The host drives each bit on a rising clock edge and the block samples it on the falling edge, most significant bit first. When the frame is complete, the command byte and its operand bytes go to a debug core over a valid/ready handshake.

When a reply is requested, the block takes over the data line at the next rising edge and holds it low until the core hands over the reply byte. It then raises the line as a ready flag, shifts the eight reply bits out on the following rising edges, and releases the line after the eighth falling edge. All logic runs on the system clock. The pins pass through two-flop synchronizers and the clock edges are found in the system domain. Each phase of the debug clock must last at least six system cycles so that a reply bit settles before the host samples it.

Top module: `dbg2w_slave`

States, named as in the RTL:
- Mode tracker: `M_GPIO` (pins free), `M_GPIO_ARM` (reset low, counting edges), `M_DEBUG` (debug mode, frame engine running), `M_DEBUG_ARM` (reset low inside debug mode, counting edges).
  - `M_GPIO` goes to `M_GPIO_ARM` when reset falls. `M_GPIO_ARM` goes to `M_DEBUG` when reset rises after exactly two edges, and back to `M_GPIO` otherwise.
  - `M_DEBUG` goes to `M_DEBUG_ARM` when reset falls. `M_DEBUG_ARM` goes to `M_GPIO` when reset rises after zero edges, and back to `M_DEBUG` otherwise.
- Frame engine: `F_OFF`, `F_CMD`, `F_OPS`, `F_RSP_ARM`, `F_RSP_WAIT`, `F_RSP_RDY`, `F_RSP_SHIFT`.
  - `F_OFF` goes to `F_CMD` once debug mode is active.
  - `F_CMD` goes to `F_OPS` after a command byte with a nonzero operand count. It goes to `F_RSP_ARM` after a command byte with no operands and the reply flag set, and stays in `F_CMD` after one with no operands and no reply flag.
  - `F_OPS` goes to `F_RSP_ARM` or back to `F_CMD` after the last operand byte, depending on the reply flag.
  - `F_RSP_ARM` goes at the next rising edge to `F_RSP_RDY` if the reply is already held, and to `F_RSP_WAIT` if it is not.
  - `F_RSP_WAIT` goes to `F_RSP_RDY` when the core supplies the reply.
  - `F_RSP_RDY` goes to `F_RSP_SHIFT` on the next rising edge.
  - `F_RSP_SHIFT` goes back to `F_CMD` after the eighth falling edge.
  - Any state goes to `F_OFF` when debug mode stops or reset is low.

## Requirements
- R1: Debug mode (`dbg_mode_o` high) starts when the synchronized reset rises after exactly two debug clock rising edges were seen while it was low. Zero, one or three edges leave the pins in general-purpose mode.
- R2: Inside debug mode, a low pulse on reset with no clock edges leaves debug mode. A low pulse carrying two clock edges keeps debug mode.
- R3: Outside debug mode, `ddat_oe_o` stays low, `rsp_ready_o` stays low, and clock or data activity produces no command.
- R4: Every host byte is sampled on falling debug clock edges, most significant bit first.
- R5: Bits [1:0] of the command byte give the operand count (0 to 3). `cmd_valid_o` rises only after the last operand byte. The first operand appears in `cmd_ops_o[7:0]`, the second in [15:8] and the third in [23:16], and unused operand bytes read as zero.
- R6: While `cmd_valid_o` is high and `cmd_ready_i` is low, `cmd_valid_o`, `cmd_byte_o` and `cmd_ops_o` hold their values.
- R7: Bit 2 of the command byte requests a reply. With bit 2 set, `ddat_oe_o` rises at the first rising debug clock edge after the frame's last byte and not earlier. With bit 2 clear, the line is never driven.
- R8: While the driver is on and no reply byte has been accepted, `ddat_o` is low. Once the reply byte is accepted, `ddat_o` is high until the next rising edge.
- R9: The reply byte leaves most significant bit first, with one new bit after each following rising edge. `ddat_oe_o` falls after the eighth falling edge.
- R10: `rsp_ready_o` is high only while a reply is awaited and none has been accepted, and a reply byte is accepted once per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset of the block's own registers |
| chip_rst_n_i | input | 1 | Chip reset pin being watched, active low |
| dclk_i | input | 1 | Debug clock pin |
| ddat_i | input | 1 | Data pin, input side |
| ddat_o | output | 1 | Data pin, output value |
| ddat_oe_o | output | 1 | Data pin output enable |
| dbg_mode_o | output | 1 | High while in debug mode |
| cmd_valid_o | output | 1 | A complete command frame is offered |
| cmd_ready_i | input | 1 | Debug core accepts the frame |
| cmd_byte_o | output | BYTE_W | Command byte |
| cmd_ops_o | output | 3*BYTE_W | Operand bytes, first in lowest byte |
| rsp_valid_i | input | 1 | Debug core offers the reply byte |
| rsp_ready_o | output | 1 | Block is waiting for the reply byte |
| rsp_data_i | input | BYTE_W | Reply byte |

## Verification
The assertions assume that each phase of the debug clock lasts several system cycles. They also assume that the host changes data only together with a rising edge, that the debug core accepts a frame before the host starts the next one, and that reset never changes in the same cycle as a debug clock edge. The bench holds every clock phase for eight system cycles and drives the data with the rising edge. It accepts each offered frame before sending the next, and it changes reset only while the debug clock is low and quiet. Reply reads are done only after a command whose reply flag is set, so the host and the block never drive the line together.

// File: rtl/dbg2w_pkg.sv
package dbg2w_pkg;

    // Command byte field layout
    localparam int unsigned OPS_FIELD_W  = 2;
    localparam int unsigned RSP_FLAG_BIT = 2;
    localparam int unsigned MAX_OPS      = (1 << OPS_FIELD_W) - 1;

    // Number of clock edges that arm debug mode
    localparam int unsigned ENTRY_EDGES  = 2;

    typedef enum logic [1:0] {
        M_GPIO,
        M_GPIO_ARM,
        M_DEBUG,
        M_DEBUG_ARM
    } mode_st_e;

    typedef enum logic [2:0] {
        F_OFF,
        F_CMD,
        F_OPS,
        F_RSP_ARM,
        F_RSP_WAIT,
        F_RSP_RDY,
        F_RSP_SHIFT
    } frame_st_e;

endpackage

// File: rtl/dbg2w_sync.sv
module dbg2w_sync #(
    parameter int unsigned       WIDTH   = 1,
    parameter int unsigned       STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/dbg2w_edge.sv
module dbg2w_edge #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise,
    output logic fall
);

    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= level;
    end

    assign rise = level & ~prev_q;
    assign fall = ~level & prev_q;

endmodule

// File: rtl/dbg2w_entry.sv
module dbg2w_entry
    import dbg2w_pkg::*;
#(
    parameter int unsigned CNT_W = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     rst_s,
    input  logic     dclk_rise,
    output logic     dbg_mode,
    output logic     engine_en,
    output mode_st_e mstate
);

    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ARM  = CNT_W'(ENTRY_EDGES);
    localparam logic [CNT_W-1:0] CNT_NONE = '0;

    mode_st_e         state_q, state_d;
    logic [CNT_W-1:0] edge_cnt_q;
    logic [CNT_W-1:0] edge_cnt_inc;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= M_GPIO;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            M_GPIO:      if (!rst_s) state_d = M_GPIO_ARM;
            M_GPIO_ARM:  if (rst_s)  state_d = (edge_cnt_q == CNT_ARM)  ? M_DEBUG : M_GPIO;
            M_DEBUG:     if (!rst_s) state_d = M_DEBUG_ARM;
            M_DEBUG_ARM: if (rst_s)  state_d = (edge_cnt_q == CNT_NONE) ? M_GPIO  : M_DEBUG;
            default:     state_d = M_GPIO;
        endcase
    end

    // Saturating edge counter, live only while reset is held low
    assign edge_cnt_inc = (edge_cnt_q == CNT_MAX) ? edge_cnt_q : edge_cnt_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_cnt_q <= '0;
        end else begin
            unique case (state_q)
                M_GPIO_ARM, M_DEBUG_ARM: if (dclk_rise) edge_cnt_q <= edge_cnt_inc;
                default:                 edge_cnt_q <= '0;
            endcase
        end
    end

    // Outputs
    always_comb begin
        dbg_mode  = (state_q == M_DEBUG) || (state_q == M_DEBUG_ARM);
        engine_en = (state_q == M_DEBUG);
        mstate    = state_q;
    end

endmodule

// File: rtl/dbg2w_frame.sv
module dbg2w_frame
    import dbg2w_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en,
    input  logic                      dat_s,
    input  logic                      dclk_rise,
    input  logic                      dclk_fall,
    output logic                      cmd_valid_o,
    input  logic                      cmd_ready_i,
    output logic [BYTE_W-1:0]         cmd_byte_o,
    output logic [MAX_OPS*BYTE_W-1:0] cmd_ops_o,
    input  logic                      rsp_valid_i,
    output logic                      rsp_ready_o,
    input  logic [BYTE_W-1:0]         rsp_data_i,
    output logic                      pin_out_o,
    output logic                      pin_oe_o,
    output frame_st_e                 fstate_o
);

    localparam int unsigned OPS_BITS = MAX_OPS * BYTE_W;
    localparam int unsigned BIT_W    = $clog2(BYTE_W);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);

    frame_st_e              state_q, state_d;
    logic [BIT_W-1:0]       bit_cnt_q;
    logic [OPS_FIELD_W-1:0] op_cnt_q;
    logic [OPS_FIELD_W-1:0] nops_q;
    logic                   rsp_req_q;
    logic                   rsp_have_q;
    logic [BYTE_W-1:0]      shreg_q;
    logic [BYTE_W-1:0]      cmd_q;
    logic [OPS_BITS-1:0]    ops_acc_q;
    logic [BYTE_W-1:0]      tx_q;

    logic [BYTE_W-1:0]      new_byte;
    logic                   byte_done;
    logic [OPS_FIELD_W-1:0] new_nops;
    logic                   new_rsp;
    logic                   last_op;
    logic                   rsp_fire;
    logic [OPS_BITS-1:0]    ops_ins;

    // Shared decode
    always_comb begin
        new_byte  = {shreg_q[BYTE_W-2:0], dat_s};
        byte_done = dclk_fall && (bit_cnt_q == BIT_LAST);
        new_nops  = new_byte[OPS_FIELD_W-1:0];
        new_rsp   = new_byte[RSP_FLAG_BIT];
        last_op   = ((op_cnt_q + 1'b1) == nops_q);
        ops_ins   = ops_acc_q;
        for (int k = 0; k < int'(MAX_OPS); k++) begin
            if (op_cnt_q == OPS_FIELD_W'(k)) ops_ins[k*BYTE_W +: BYTE_W] = new_byte;
        end
    end

    assign rsp_ready_o = ((state_q == F_RSP_ARM) || (state_q == F_RSP_WAIT)) && !rsp_have_q;
    assign rsp_fire    = rsp_ready_o && rsp_valid_i;
    assign fstate_o    = state_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= F_OFF;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = F_OFF;
        end else begin
            unique case (state_q)
                F_OFF: state_d = F_CMD;
                F_CMD: begin
                    if (byte_done) begin
                        if (new_nops != '0) state_d = F_OPS;
                        else if (new_rsp)   state_d = F_RSP_ARM;
                        else                state_d = F_CMD;
                    end
                end
                F_OPS: begin
                    if (byte_done && last_op) state_d = rsp_req_q ? F_RSP_ARM : F_CMD;
                end
                F_RSP_ARM: begin
                    if (dclk_rise) state_d = (rsp_have_q || rsp_fire) ? F_RSP_RDY : F_RSP_WAIT;
                end
                F_RSP_WAIT:  if (rsp_fire)  state_d = F_RSP_RDY;
                F_RSP_RDY:   if (dclk_rise) state_d = F_RSP_SHIFT;
                F_RSP_SHIFT: if (byte_done) state_d = F_CMD;
                default:     state_d = F_OFF;
            endcase
        end
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q   <= '0;
            op_cnt_q    <= '0;
            nops_q      <= '0;
            rsp_req_q   <= 1'b0;
            rsp_have_q  <= 1'b0;
            shreg_q     <= '0;
            cmd_q       <= '0;
            ops_acc_q   <= '0;
            tx_q        <= '0;
            cmd_valid_o <= 1'b0;
            cmd_byte_o  <= '0;
            cmd_ops_o   <= '0;
            pin_out_o   <= 1'b0;
            pin_oe_o    <= 1'b0;
        end else begin
            if (cmd_valid_o && cmd_ready_i) cmd_valid_o <= 1'b0;

            if (!en) begin
                bit_cnt_q  <= '0;
                rsp_have_q <= 1'b0;
                pin_out_o  <= 1'b0;
                pin_oe_o   <= 1'b0;
            end else begin
                unique case (state_q)
                    F_OFF: begin
                        bit_cnt_q <= '0;
                    end
                    F_CMD: begin
                        if (dclk_fall) begin
                            shreg_q   <= new_byte;
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end
                        if (byte_done) begin
                            cmd_q      <= new_byte;
                            nops_q     <= new_nops;
                            rsp_req_q  <= new_rsp;
                            rsp_have_q <= 1'b0;
                            op_cnt_q   <= '0;
                            ops_acc_q  <= '0;
                            if (new_nops == '0) begin
                                cmd_valid_o <= 1'b1;
                                cmd_byte_o  <= new_byte;
                                cmd_ops_o   <= '0;
                            end
                        end
                    end
                    F_OPS: begin
                        if (dclk_fall) begin
                            shreg_q   <= new_byte;
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end
                        if (byte_done) begin
                            ops_acc_q <= ops_ins;
                            op_cnt_q  <= op_cnt_q + 1'b1;
                            if (last_op) begin
                                cmd_valid_o <= 1'b1;
                                cmd_byte_o  <= cmd_q;
                                cmd_ops_o   <= ops_ins;
                            end
                        end
                    end
                    F_RSP_ARM: begin
                        if (rsp_fire) begin
                            tx_q       <= rsp_data_i;
                            rsp_have_q <= 1'b1;
                        end
                        if (dclk_rise) begin
                            pin_oe_o  <= 1'b1;
                            pin_out_o <= rsp_have_q || rsp_fire;
                        end
                    end
                    F_RSP_WAIT: begin
                        if (rsp_fire) begin
                            tx_q       <= rsp_data_i;
                            rsp_have_q <= 1'b1;
                            pin_out_o  <= 1'b1;
                        end
                    end
                    F_RSP_RDY: begin
                        if (dclk_rise) begin
                            pin_out_o <= tx_q[BYTE_W-1];
                            tx_q      <= {tx_q[BYTE_W-2:0], 1'b0};
                            bit_cnt_q <= '0;
                        end
                    end
                    F_RSP_SHIFT: begin
                        if (dclk_rise) begin
                            pin_out_o <= tx_q[BYTE_W-1];
                            tx_q      <= {tx_q[BYTE_W-2:0], 1'b0};
                        end
                        if (dclk_fall) bit_cnt_q <= bit_cnt_q + 1'b1;
                        if (byte_done) begin
                            pin_oe_o   <= 1'b0;
                            pin_out_o  <= 1'b0;
                            rsp_have_q <= 1'b0;
                        end
                    end
                    default: begin
                        bit_cnt_q <= '0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/dbg2w_slave.sv
module dbg2w_slave
    import dbg2w_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned BYTE_W      = 8,
    parameter int unsigned ENTRY_CNT_W = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      chip_rst_n_i,
    input  logic                      dclk_i,
    input  logic                      ddat_i,
    output logic                      ddat_o,
    output logic                      ddat_oe_o,
    output logic                      dbg_mode_o,
    output logic                      cmd_valid_o,
    input  logic                      cmd_ready_i,
    output logic [BYTE_W-1:0]         cmd_byte_o,
    output logic [MAX_OPS*BYTE_W-1:0] cmd_ops_o,
    input  logic                      rsp_valid_i,
    output logic                      rsp_ready_o,
    input  logic [BYTE_W-1:0]         rsp_data_i
);

    localparam int unsigned PIN_N = 3;

    logic      rst_s;
    logic      dat_s;
    logic      dclk_s;
    logic      dclk_rise;
    logic      dclk_fall;
    logic      engine_en;
    mode_st_e  mstate;
    frame_st_e fstate;

    dbg2w_sync #(
        .WIDTH   (PIN_N),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({chip_rst_n_i, ddat_i, dclk_i}),
        .q     ({rst_s, dat_s, dclk_s})
    );

    dbg2w_edge #(
        .RST_VAL (1'b0)
    ) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (dclk_s),
        .rise  (dclk_rise),
        .fall  (dclk_fall)
    );

    dbg2w_entry #(
        .CNT_W (ENTRY_CNT_W)
    ) u_entry (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_s     (rst_s),
        .dclk_rise (dclk_rise),
        .dbg_mode  (dbg_mode_o),
        .engine_en (engine_en),
        .mstate    (mstate)
    );

    dbg2w_frame #(
        .BYTE_W (BYTE_W)
    ) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (engine_en),
        .dat_s       (dat_s),
        .dclk_rise   (dclk_rise),
        .dclk_fall   (dclk_fall),
        .cmd_valid_o (cmd_valid_o),
        .cmd_ready_i (cmd_ready_i),
        .cmd_byte_o  (cmd_byte_o),
        .cmd_ops_o   (cmd_ops_o),
        .rsp_valid_i (rsp_valid_i),
        .rsp_ready_o (rsp_ready_o),
        .rsp_data_i  (rsp_data_i),
        .pin_out_o   (ddat_o),
        .pin_oe_o    (ddat_oe_o),
        .fstate_o    (fstate)
    );

endmodule

// File: rtl/dbg2w_slave_chk.sv
module dbg2w_slave_chk
    import dbg2w_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      rst_s,
    input logic                      dclk_rise,
    input logic                      dbg_mode_o,
    input logic                      ddat_o,
    input logic                      ddat_oe_o,
    input logic                      cmd_valid_o,
    input logic                      cmd_ready_i,
    input logic [BYTE_W-1:0]         cmd_byte_o,
    input logic [MAX_OPS*BYTE_W-1:0] cmd_ops_o,
    input logic                      rsp_ready_o,
    input frame_st_e                 fstate
);

    p_enter_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dbg_mode_o) |-> $past(rst_s));

    p_exit_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dbg_mode_o) |-> $past(rst_s));

    p_no_drive_gpio_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !dbg_mode_o |-> !ddat_oe_o);

    p_cmd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && !cmd_ready_i) |=>
            (cmd_valid_o && $stable(cmd_byte_o) && $stable(cmd_ops_o)));

    p_wait_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ddat_oe_o && fstate == F_RSP_WAIT) |-> !ddat_o);

    p_pin_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ddat_oe_o && $past(ddat_oe_o) && (ddat_o != $past(ddat_o))) |->
            ($past(dclk_rise) || $past(fstate) == F_RSP_WAIT));

    p_rsp_ready_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready_o |-> dbg_mode_o);

endmodule

bind dbg2w_slave dbg2w_slave_chk #(
    .BYTE_W (BYTE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rst_s       (rst_s),
    .dclk_rise   (dclk_rise),
    .dbg_mode_o  (dbg_mode_o),
    .ddat_o      (ddat_o),
    .ddat_oe_o   (ddat_oe_o),
    .cmd_valid_o (cmd_valid_o),
    .cmd_ready_i (cmd_ready_i),
    .cmd_byte_o  (cmd_byte_o),
    .cmd_ops_o   (cmd_ops_o),
    .rsp_ready_o (rsp_ready_o),
    .fstate      (fstate)
);

// File: tb/dbg2w_slave_tb.sv
`timescale 1ns/1ps
module dbg2w_slave_tb;

    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chip_rst_n = 1'b1;
    logic        dclk = 1'b0;
    logic        ddat = 1'b0;
    logic        ddat_o;
    logic        ddat_oe_o;
    logic        dbg_mode_o;
    logic        cmd_valid_o;
    logic        cmd_ready = 1'b0;
    logic [7:0]  cmd_byte_o;
    logic [23:0] cmd_ops_o;
    logic        rsp_valid = 1'b0;
    logic        rsp_ready_o;
    logic [7:0]  rsp_data = 8'h00;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dbg2w_slave u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .chip_rst_n_i (chip_rst_n),
        .dclk_i       (dclk),
        .ddat_i       (ddat),
        .ddat_o       (ddat_o),
        .ddat_oe_o    (ddat_oe_o),
        .dbg_mode_o   (dbg_mode_o),
        .cmd_valid_o  (cmd_valid_o),
        .cmd_ready_i  (cmd_ready),
        .cmd_byte_o   (cmd_byte_o),
        .cmd_ops_o    (cmd_ops_o),
        .rsp_valid_i  (rsp_valid),
        .rsp_ready_o  (rsp_ready_o),
        .rsp_data_i   (rsp_data)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_bit(input logic b);
        @(negedge clk);
        dclk = 1'b1;
        ddat = b;
        wait_cyc(HALF);
        dclk = 1'b0;
        wait_cyc(HALF);
    endtask

    task automatic host_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) host_bit(v[i]);
    endtask

    task automatic read_bit(output logic oe, output logic d);
        @(negedge clk);
        dclk = 1'b1;
        ddat = 1'b0;
        wait_cyc(HALF);
        oe = ddat_oe_o;
        d  = ddat_o;
        dclk = 1'b0;
        wait_cyc(HALF);
    endtask

    task automatic entry_seq(input int edges);
        @(negedge clk);
        chip_rst_n = 1'b0;
        wait_cyc(HALF);
        for (int i = 0; i < edges; i++) host_bit(1'b0);
        wait_cyc(HALF);
        chip_rst_n = 1'b1;
        wait_cyc(HALF);
    endtask

    task automatic accept_cmd(input logic [7:0] eb, input logic [23:0] eo, input string tag);
        chk(int'(cmd_valid_o), 1, {tag, " cmd_valid"});
        chk(int'(cmd_byte_o), int'(eb), {tag, " cmd_byte"});
        chk(int'(cmd_ops_o), int'(eo), {tag, " cmd_ops"});
        @(negedge clk);
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
        chk(int'(cmd_valid_o), 0, {tag, " valid drop"});
    endtask

    task automatic give_rsp(input logic [7:0] v);
        @(negedge clk);
        rsp_valid = 1'b1;
        rsp_data  = v;
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    task automatic read_reply(input logic [7:0] exp, input string tag);
        logic oe, d;
        for (int i = 7; i >= 0; i--) begin
            read_bit(oe, d);
            chk(int'(oe), 1, {tag, " R9 oe during bit"});
            chk(int'(d), int'(exp[i]), {tag, " R9 reply bit"});
        end
        chk(int'(ddat_oe_o), 0, {tag, " R9 release after eighth bit"});
    endtask

    task automatic t_reset;
        chk(int'(dbg_mode_o), 0, "R3 reset dbg_mode");
        chk(int'(ddat_oe_o), 0, "R3 reset oe");
        chk(int'(cmd_valid_o), 0, "R3 reset cmd_valid");
        chk(int'(rsp_ready_o), 0, "R10 reset rsp_ready");
    endtask

    task automatic t_gpio_ignored;
        host_byte(8'h04);
        host_byte(8'hFF);
        chk(int'(cmd_valid_o), 0, "R3 no command in gpio");
        chk(int'(ddat_oe_o), 0, "R3 no drive in gpio");
        chk(int'(rsp_ready_o), 0, "R3 no reply wait in gpio");
        chk(int'(dbg_mode_o), 0, "R3 stays gpio");
    endtask

    task automatic t_entry;
        entry_seq(1);
        chk(int'(dbg_mode_o), 0, "R1 one edge no entry");
        entry_seq(3);
        chk(int'(dbg_mode_o), 0, "R1 three edges no entry");
        entry_seq(0);
        chk(int'(dbg_mode_o), 0, "R1 zero edges no entry");
        entry_seq(2);
        chk(int'(dbg_mode_o), 1, "R1 two edges enter");
        chk(int'(ddat_oe_o), 0, "R7 idle not driving");
    endtask

    task automatic t_frames;
        host_byte(8'h80);
        accept_cmd(8'h80, 24'h0, "R4 msb first single byte");
        host_byte(8'h03);
        host_byte(8'h11);
        host_byte(8'h22);
        chk(int'(cmd_valid_o), 0, "R5 no handoff before last operand");
        host_byte(8'h33);
        accept_cmd(8'h03, 24'h332211, "R5 three operands");
        host_byte(8'h02);
        host_byte(8'hAB);
        host_byte(8'hCD);
        wait_cyc(30);
        chk(int'(cmd_valid_o), 1, "R6 valid held");
        chk(int'(cmd_byte_o), 8'h02, "R6 byte held");
        chk(int'(cmd_ops_o), 24'h00CDAB, "R6 ops held");
        accept_cmd(8'h02, 24'h00CDAB, "R5 two operands");
    endtask

    task automatic t_no_rsp;
        logic oe, d;
        host_byte(8'h01);
        host_byte(8'h5A);
        accept_cmd(8'h01, 24'h00005A, "R5 one operand");
        read_bit(oe, d);
        chk(int'(oe), 0, "R7 no drive without reply flag");
        for (int i = 0; i < 7; i++) host_bit(1'b0);
        accept_cmd(8'h00, 24'h0, "R4 realigned zero command");
    endtask

    task automatic t_rsp_late;
        logic oe, d;
        host_byte(8'h05);
        host_byte(8'h7E);
        accept_cmd(8'h05, 24'h00007E, "R7 reply command");
        chk(int'(ddat_oe_o), 0, "R7 no drive before edge");
        chk(int'(rsp_ready_o), 1, "R10 waiting for reply");
        read_bit(oe, d);
        chk(int'(oe), 1, "R7 drive at first rising edge");
        chk(int'(d), 0, "R8 low while not ready");
        wait_cyc(12);
        chk(int'(ddat_o), 0, "R8 still low");
        give_rsp(8'hA5);
        wait_cyc(3);
        chk(int'(rsp_ready_o), 0, "R10 ready drops after accept");
        chk(int'(ddat_o), 1, "R8 ready flag high");
        chk(int'(ddat_oe_o), 1, "R8 still driving");
        read_reply(8'hA5, "late");
        chk(int'(rsp_ready_o), 0, "R10 no further reply wait");
    endtask

    task automatic t_rsp_early;
        logic oe, d;
        host_byte(8'h04);
        accept_cmd(8'h04, 24'h0, "R7 reply no operands");
        give_rsp(8'h3C);
        wait_cyc(4);
        chk(int'(ddat_oe_o), 0, "R7 reply held but no edge yet");
        chk(int'(rsp_ready_o), 0, "R10 accepted once");
        read_bit(oe, d);
        chk(int'(oe), 1, "R7 drive at edge");
        chk(int'(d), 1, "R8 flag high when held");
        read_reply(8'h3C, "early");
        host_byte(8'h81);
        host_byte(8'h96);
        accept_cmd(8'h81, 24'h000096, "R5 frame after reply");
    endtask

    task automatic t_exit;
        entry_seq(2);
        chk(int'(dbg_mode_o), 1, "R2 two edges keep debug");
        host_byte(8'h40);
        accept_cmd(8'h40, 24'h0, "R2 engine restarts");
        entry_seq(0);
        chk(int'(dbg_mode_o), 0, "R2 zero edges leave debug");
        host_byte(8'h04);
        chk(int'(cmd_valid_o), 0, "R3 no command after exit");
        chk(int'(rsp_ready_o), 0, "R3 no reply wait after exit");
    endtask

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(5);
        t_reset();
        t_gpio_ignored();
        t_entry();
        t_frames();
        t_no_rsp();
        t_rsp_late();
        t_rsp_early();
        t_exit();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule